// File: doc/BRIEF.md
# Three-Wire Synthesizer Programming Front End

This block receives configuration for a frequency synthesizer over a three-wire serial link: a serial clock, a data line and a load strobe. It shifts in 24-bit words, most significant bit first. A rising load strobe commits the word that was shifted in. The two lowest bits of that word address the destination, so one serial stream programs three separate register maps: the reference divider settings, the A/B feedback divider settings and the function controls. Each field is presented as a decoded output. The block also derives the total feedback division ratio from the stored divider values and the prescaler choice.

A chip-enable input acts on its own, with no clock involved. While it is low the block reports power-down whatever the software bit holds. The serial path keeps working during power-down, and stored settings survive any number of chip-enable cycles. The three serial lines are asynchronous to the system clock. They pass through a synchronizer of `SYNC_STAGES` flops and are edge-detected there. Each serial level must therefore stay stable for at least `SYNC_STAGES`+2 system clocks. A 50 MHz system clock is ample for the usual update rates of a few hundred kilohertz.

Top module: `ssp_top`

## Requirements
- R1: On each rising edge of `ser_clk` the word moves up one place and takes `ser_data` as its new bit 0, so the first bit sent ends in bit 23. On a rising edge of `ser_load`, word bits [1:0] pick the destination: 00 is the reference latch, 01 the divider latch and 10 the function latch.
- R2: The reference latch takes its 14-bit divide value `ref_div` from word bits [15:2] and its 2-bit anti-backlash width `abp_width` from bits [17:16].
- R3: The divider latch takes `a_count` from word bits [7:2] and `b_count` from bits [20:8]. `n_div` always equals `b_count`*P + `a_count`, where P is the prescaler modulus.
- R4: A divider-latch word whose B field is 0, 1 or 2 is refused, and `a_count` and `b_count` keep their earlier values.
- R5: The function latch takes counter reset from bit 2, software power-down from bit 3, the multiplexer select from bits [6:4], polarity from bit 7, charge-pump three-state from bit 8 and the prescaler select from bits [23:22]. `presc_mod` is 8, 16, 32 or 64 for select values 0 to 3.
- R6: A load with control code 11 changes no latch.
- R7: `power_down` equals the software power-down bit while `chip_en` is high. It goes to 1 combinationally and at once while `chip_en` is low.
- R8: Words shifted and loaded while `chip_en` is low are stored. Stored settings are unchanged after `chip_en` goes low and then high again.
- R9: `counter_hold` is 1 exactly when the counter reset bit or `power_down` is 1. `cp_hiz` is 1 exactly when the three-state bit, the counter reset bit or `power_down` is 1.
- R10: A synchronous `rst` clears every latch to zero. Shifting bits without a rising `ser_load` changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_data | input | 1 | Serial data, first bit sent is bit 23 |
| ser_load | input | 1 | Load strobe, rising edge commits the word |
| chip_en | input | 1 | Active-high chip enable, low forces power-down |
| ref_div | output | 14 | Reference divide value |
| abp_width | output | 2 | Anti-backlash pulse-width code |
| a_count | output | 6 | Swallow counter value A |
| b_count | output | 13 | Main counter value B |
| fn_cnt_rst | output | 1 | Stored counter reset bit |
| fn_sw_pd | output | 1 | Stored software power-down bit |
| fn_mux | output | 3 | Stored output multiplexer select |
| fn_pol | output | 1 | Stored phase detector polarity |
| fn_cp_tri | output | 1 | Stored charge-pump three-state bit |
| fn_presc | output | 2 | Stored prescaler select |
| presc_mod | output | 7 | Prescaler modulus P |
| n_div | output | 19 | Total feedback divide B*P+A |
| power_down | output | 1 | Combined power-down |
| counter_hold | output | 1 | Counters held at load state |
| cp_hiz | output | 1 | Charge pump forced to high impedance |

## Verification
The bench targets the divider guard at its edge. B=2 must be refused and B=3 accepted, and a design with an off-by-one bound either stores a forbidden ratio or drops a legal one. Code 11 words carry field values that differ from every latch, so a decoder that lets code 11 through to any latch changes an output. The bench drops `chip_en` and reads `power_down` within the same system clock, which catches a registered enable path. It also loads words while powered down and checks that they survive, shifts a word with no load strobe, and checks `n_div` at the largest B and A under every prescaler, where a narrow multiplier would wrap.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  localparam int WORD_W  = 24;
  localparam int CTL_W   = 2;
  localparam int R_W     = 14;
  localparam int ABP_W   = 2;
  localparam int A_W     = 6;
  localparam int B_W     = 13;
  localparam int MUX_W   = 3;
  localparam int PS_W    = 2;
  localparam int P_W     = 7;
  localparam int N_W     = B_W + 6;
  localparam int P_BASE  = 8;
  localparam int B_MIN   = 3;

  localparam int R_LSB   = CTL_W;
  localparam int ABP_LSB = R_LSB + R_W;
  localparam int A_LSB   = CTL_W;
  localparam int B_LSB   = A_LSB + A_W;
  localparam int F_CRST  = 2;
  localparam int F_PD    = 3;
  localparam int F_MUX   = 4;
  localparam int F_POL   = F_MUX + MUX_W;
  localparam int F_TRI   = F_POL + 1;
  localparam int F_PS    = WORD_W - PS_W;

  typedef enum logic [CTL_W-1:0] {
    DST_REF  = 2'b00,
    DST_DIV  = 2'b01,
    DST_FUNC = 2'b10,
    DST_NONE = 2'b11
  } dst_e;

  typedef struct packed {
    logic [ABP_W-1:0] abp;
    logic [R_W-1:0]   rdiv;
  } ref_t;

  typedef struct packed {
    logic [B_W-1:0] b;
    logic [A_W-1:0] a;
  } div_t;

  typedef struct packed {
    logic [PS_W-1:0]  ps;
    logic             tri_st;
    logic             pol;
    logic [MUX_W-1:0] mux;
    logic             pd;
    logic             crst;
  } func_t;

  function automatic logic [P_W-1:0] presc_modulus(input logic [PS_W-1:0] sel);
    return P_W'(P_BASE) << sel;
  endfunction

  function automatic logic [N_W-1:0] total_ratio(input div_t d, input logic [P_W-1:0] p);
    logic [N_W-1:0] prod;
    prod = N_W'(d.b) * N_W'(p);
    return prod + N_W'(d.a);
  endfunction

  function automatic logic b_allowed(input logic [B_W-1:0] b);
    return b >= B_W'(B_MIN);
  endfunction

endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
  parameter int STAGES = 2,
  parameter bit EDGE   = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  localparam int DEPTH = STAGES + (EDGE ? 1 : 0);

  logic [DEPTH-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= '0;
    else     stg <= {stg[DEPTH-2:0], async_in};
  end

  generate
    if (EDGE) begin : g_edge
      assign sync_out = stg[STAGES-1] & ~stg[STAGES];
    end else begin : g_level
      assign sync_out = stg[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/ssp_shift.sv
module ssp_shift #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst)           word <= '0;
    else if (shift_en) word <= {word[W-2:0], din};
  end
endmodule

// File: rtl/ssp_latches.sv
module ssp_latches
  import ssp_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load,
  input  dst_e  dst,
  input  logic  b_ok,
  input  ref_t  ref_nx,
  input  div_t  div_nx,
  input  func_t func_nx,
  output ref_t  ref_q,
  output div_t  div_q,
  output func_t func_q
);
  logic we_ref, we_div, we_func;

  always_comb begin
    we_ref  = 1'b0;
    we_div  = 1'b0;
    we_func = 1'b0;
    if (load) begin
      unique case (dst)
        DST_REF:  we_ref  = 1'b1;
        DST_DIV:  we_div  = b_ok;
        DST_FUNC: we_func = 1'b1;
        DST_NONE: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q  <= '0;
      div_q  <= '0;
      func_q <= '0;
    end else begin
      if (we_ref)  ref_q  <= ref_nx;
      if (we_div)  div_q  <= div_nx;
      if (we_func) func_q <= func_nx;
    end
  end
endmodule

// File: rtl/ssp_top.sv
module ssp_top
  import ssp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_clk,
  input  logic             ser_data,
  input  logic             ser_load,
  input  logic             chip_en,
  output logic [R_W-1:0]   ref_div,
  output logic [ABP_W-1:0] abp_width,
  output logic [A_W-1:0]   a_count,
  output logic [B_W-1:0]   b_count,
  output logic             fn_cnt_rst,
  output logic             fn_sw_pd,
  output logic [MUX_W-1:0] fn_mux,
  output logic             fn_pol,
  output logic             fn_cp_tri,
  output logic [PS_W-1:0]  fn_presc,
  output logic [P_W-1:0]   presc_mod,
  output logic [N_W-1:0]   n_div,
  output logic             power_down,
  output logic             counter_hold,
  output logic             cp_hiz
);
  // Events brought out as named wires for the checker
  logic              shift_evt;
  logic              load_evt;
  logic              data_bit;
  logic [WORD_W-1:0] sh_word;
  dst_e              dst;
  logic              b_ok;
  ref_t              ref_nx, ref_q;
  div_t              div_nx, div_q;
  func_t             func_nx, func_q;

  ssp_sync #(.STAGES(SYNC_STAGES), .EDGE(1'b1)) u_sync_clk (
    .clk(clk), .rst(rst), .async_in(ser_clk), .sync_out(shift_evt));
  ssp_sync #(.STAGES(SYNC_STAGES), .EDGE(1'b0)) u_sync_dat (
    .clk(clk), .rst(rst), .async_in(ser_data), .sync_out(data_bit));
  ssp_sync #(.STAGES(SYNC_STAGES), .EDGE(1'b1)) u_sync_ld (
    .clk(clk), .rst(rst), .async_in(ser_load), .sync_out(load_evt));

  ssp_shift #(.W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .shift_en(shift_evt), .din(data_bit), .word(sh_word));

  assign dst            = dst_e'(sh_word[CTL_W-1:0]);
  assign ref_nx.rdiv    = sh_word[R_LSB +: R_W];
  assign ref_nx.abp     = sh_word[ABP_LSB +: ABP_W];
  assign div_nx.a       = sh_word[A_LSB +: A_W];
  assign div_nx.b       = sh_word[B_LSB +: B_W];
  assign func_nx.crst   = sh_word[F_CRST];
  assign func_nx.pd     = sh_word[F_PD];
  assign func_nx.mux    = sh_word[F_MUX +: MUX_W];
  assign func_nx.pol    = sh_word[F_POL];
  assign func_nx.tri_st = sh_word[F_TRI];
  assign func_nx.ps     = sh_word[F_PS +: PS_W];
  assign b_ok           = b_allowed(div_nx.b);

  ssp_latches u_latches (
    .clk(clk), .rst(rst), .load(load_evt), .dst(dst), .b_ok(b_ok),
    .ref_nx(ref_nx), .div_nx(div_nx), .func_nx(func_nx),
    .ref_q(ref_q), .div_q(div_q), .func_q(func_q));

  assign ref_div    = ref_q.rdiv;
  assign abp_width  = ref_q.abp;
  assign a_count    = div_q.a;
  assign b_count    = div_q.b;
  assign fn_cnt_rst = func_q.crst;
  assign fn_sw_pd   = func_q.pd;
  assign fn_mux     = func_q.mux;
  assign fn_pol     = func_q.pol;
  assign fn_cp_tri  = func_q.tri_st;
  assign fn_presc   = func_q.ps;
  assign presc_mod  = presc_modulus(func_q.ps);
  assign n_div      = total_ratio(div_q, presc_mod);

  assign power_down   = ~chip_en | func_q.pd;
  assign counter_hold = func_q.crst | power_down;
  assign cp_hiz       = func_q.tri_st | func_q.crst | power_down;
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker
  import ssp_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              chip_en,
  input logic              shift_evt,
  input logic              load_evt,
  input logic [WORD_W-1:0] sh_word,
  input ref_t              ref_q,
  input div_t              div_q,
  input func_t             func_q,
  input logic              fn_cnt_rst,
  input logic              power_down,
  input logic              counter_hold,
  input logic              cp_hiz
);
  AST_CE_FORCES_PD: assert property (@(posedge clk) disable iff (rst)
    !chip_en |-> power_down); // R7

  AST_PD_HOLDS_COUNTERS: assert property (@(posedge clk) disable iff (rst)
    power_down |-> (counter_hold && cp_hiz)); // R9

  AST_CRST_HOLDS: assert property (@(posedge clk) disable iff (rst)
    fn_cnt_rst |-> (counter_hold && cp_hiz)); // R9

  AST_IDLE_LATCHES: assert property (@(posedge clk) disable iff (rst)
    !load_evt |=> ($stable(ref_q) && $stable(div_q) && $stable(func_q))); // R10

  AST_IDLE_SHIFT: assert property (@(posedge clk) disable iff (rst)
    !shift_evt |=> $stable(sh_word)); // R10

  AST_CODE11_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (load_evt && sh_word[CTL_W-1:0] == 2'b11)
      |=> ($stable(ref_q) && $stable(div_q) && $stable(func_q))); // R6

  AST_BAD_B_REFUSED: assert property (@(posedge clk) disable iff (rst)
    (load_evt && sh_word[CTL_W-1:0] == 2'b01 && sh_word[B_LSB +: B_W] < B_W'(B_MIN))
      |=> $stable(div_q)); // R4

  AST_REF_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (load_evt && sh_word[CTL_W-1:0] == 2'b00)
      |=> (ref_q == $past(sh_word[ABP_LSB+ABP_W-1:R_LSB]))); // R2
endmodule

bind ssp_top ssp_checker u_ssp_checker (
  .clk(clk), .rst(rst), .chip_en(chip_en), .shift_evt(shift_evt),
  .load_evt(load_evt), .sh_word(sh_word), .ref_q(ref_q), .div_q(div_q),
  .func_q(func_q), .fn_cnt_rst(fn_cnt_rst), .power_down(power_down),
  .counter_hold(counter_hold), .cp_hiz(cp_hiz));

// File: tb/test_ssp_top.sv
module test_ssp_top;
  localparam int HOLD     = 4;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0, chip_en = 1'b1;
  logic [13:0] ref_div;
  logic [1:0]  abp_width;
  logic [5:0]  a_count;
  logic [12:0] b_count;
  logic        fn_cnt_rst, fn_sw_pd, fn_pol, fn_cp_tri;
  logic [2:0]  fn_mux;
  logic [1:0]  fn_presc;
  logic [6:0]  presc_mod;
  logic [18:0] n_div;
  logic        power_down, counter_hold, cp_hiz;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 1'b0;

  // Bench model of the stored settings
  logic [13:0] m_r;   logic [1:0] m_abp;
  logic [5:0]  m_a;   logic [12:0] m_b;
  logic m_crst, m_pd, m_pol, m_tri;
  logic [2:0] m_mux;  logic [1:0] m_ps;

  always #10 clk = ~clk;

  ssp_top i_ssp_top (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_load(ser_load), .chip_en(chip_en), .ref_div(ref_div),
    .abp_width(abp_width), .a_count(a_count), .b_count(b_count),
    .fn_cnt_rst(fn_cnt_rst), .fn_sw_pd(fn_sw_pd), .fn_mux(fn_mux),
    .fn_pol(fn_pol), .fn_cp_tri(fn_cp_tri), .fn_presc(fn_presc),
    .presc_mod(presc_mod), .n_div(n_div), .power_down(power_down),
    .counter_hold(counter_hold), .cp_hiz(cp_hiz));

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [6:0] exp_mod(input logic [1:0] s);
    case (s)
      2'd0: return 7'd8;
      2'd1: return 7'd16;
      2'd2: return 7'd32;
      default: return 7'd64;
    endcase
  endfunction

  function automatic logic [18:0] exp_n(input logic [12:0] b, input logic [5:0] a, input logic [1:0] s);
    int unsigned t;
    t = b * exp_mod(s) + a;
    return t[18:0];
  endfunction

  task automatic model_clear();
    m_r = '0; m_abp = '0; m_a = '0; m_b = '0;
    m_crst = 0; m_pd = 0; m_pol = 0; m_tri = 0; m_mux = '0; m_ps = '0;
  endtask

  task automatic model_load(input logic [23:0] w);
    case (w[1:0])
      2'b00: begin m_r = w[15:2]; m_abp = w[17:16]; end
      2'b01: if (w[20:8] >= 13'd3) begin m_a = w[7:2]; m_b = w[20:8]; end
      2'b10: begin
        m_crst = w[2]; m_pd = w[3]; m_mux = w[6:4];
        m_pol = w[7]; m_tri = w[8]; m_ps = w[23:22];
      end
      default: ;
    endcase
  endtask

  task automatic send_word(input logic [23:0] w, input bit do_load);
    for (int i = 23; i >= 0; i--) begin
      ser_data = w[i];
      idle(HOLD);
      ser_clk = 1'b1;
      idle(HOLD);
      ser_clk = 1'b0;
    end
    idle(HOLD);
    if (do_load) begin
      ser_load = 1'b1;
      idle(HOLD);
      ser_load = 1'b0;
      model_load(w);
    end
    idle(8);
  endtask

  task automatic check_all();
    logic pd;
    pd = !chip_en | m_pd;
    chk("R1 R2 ref_div", 32'(ref_div), 32'(m_r));
    chk("R2 abp_width", 32'(abp_width), 32'(m_abp));
    chk("R1 R3 a_count", 32'(a_count), 32'(m_a));
    chk("R3 R4 b_count", 32'(b_count), 32'(m_b));
    chk("R5 func fields", {26'd0, fn_presc, fn_cp_tri, fn_pol, fn_mux},
                          {26'd0, m_ps, m_tri, m_pol, m_mux});
    chk("R5 bits", {30'd0, fn_cnt_rst, fn_sw_pd}, {30'd0, m_crst, m_pd});
    chk("R5 presc_mod", 32'(presc_mod), 32'(exp_mod(m_ps)));
    chk("R3 n_div", 32'(n_div), 32'(exp_n(m_b, m_a, m_ps)));
    chk("R7 power_down", 32'(power_down), 32'(pd));
    chk("R9 controls", {30'd0, counter_hold, cp_hiz},
                       {30'd0, m_crst | pd, m_tri | m_crst | pd});
  endtask

  function automatic logic [23:0] fword(input logic [1:0] ps, input logic tri_b,
      input logic pol, input logic [2:0] mux, input logic pd, input logic crst);
    return {ps, 13'd0, tri_b, pol, mux, pd, crst, 2'b10};
  endfunction

  initial begin
    logic [23:0] w;
    int unsigned r;
    model_clear();
    r = $urandom(32'd20250611);
    idle(5);
    rst = 1'b0;
    idle(3);
    // R10: reset state is all zeros
    check_all();

    // Directed: reference latch
    send_word({6'd0, 2'b11, 14'h3FFF, 2'b00}, 1'b1); check_all();
    // R4 boundary: B=3 accepted, B=2 refused
    send_word({3'd0, 13'd3, 6'd17, 2'b01}, 1'b1);
    chk("R4 B=3 accepted", 32'(b_count), 32'd3);
    send_word({3'd0, 13'd2, 6'd40, 2'b01}, 1'b1);
    chk("R4 B=2 refused", 32'(b_count), 32'd3);
    chk("R4 A unchanged", 32'(a_count), 32'd17);
    send_word({3'd0, 13'd0, 6'd63, 2'b01}, 1'b1); check_all();
    // R3/R5 every prescaler at maximum B and A
    send_word({3'd0, 13'd8191, 6'd63, 2'b01}, 1'b1);
    for (int s = 0; s < 4; s++) begin
      send_word(fword(2'(s), 1'b0, 1'b1, 3'(s + 1), 1'b0, 1'b0), 1'b1);
      check_all();
    end
    // R6: code 11 with fields unlike any stored value
    send_word(24'hA5A5A7, 1'b1); check_all();
    send_word(24'h5A5A5B, 1'b1); check_all();
    // R10: shifting with no load strobe
    send_word({6'd0, 2'b01, 14'h1234, 2'b00}, 1'b0); check_all();
    // R9: counter reset and three-state
    send_word(fword(2'd1, 1'b0, 1'b0, 3'd2, 1'b0, 1'b1), 1'b1); check_all();
    send_word(fword(2'd1, 1'b1, 1'b0, 3'd2, 1'b0, 1'b0), 1'b1); check_all();
    // R7: chip enable low acts at once, without a clock edge
    chip_en = 1'b0;
    #1;
    chk("R7 immediate power_down", 32'(power_down), 32'd1);
    chk("R9 hold during pd", {30'd0, counter_hold, cp_hiz}, 32'd3);
    // R8: loading while powered down
    send_word({6'd0, 2'b10, 14'd999, 2'b00}, 1'b1);
    send_word({3'd0, 13'd500, 6'd9, 2'b01}, 1'b1);
    check_all();
    chip_en = 1'b1;
    idle(2);
    chk("R8 ref kept after ce cycle", 32'(ref_div), 32'd999);
    chk("R8 b kept after ce cycle", 32'(b_count), 32'd500);
    check_all();
    // R7: software power-down with chip enable high
    send_word(fword(2'd2, 1'b0, 1'b0, 3'd5, 1'b1, 1'b0), 1'b1);
    chk("R7 software pd", 32'(power_down), 32'd1);
    check_all();

    // Random words
    for (int k = 0; k < 160; k++) begin
      w = 24'($urandom());
      if (k % 5 == 0) w[20:8] = 13'($urandom_range(0, 4));
      send_word(w, ($urandom_range(0, 9) != 0));
      if (k % 7 == 3) begin
        chip_en = 1'b0;
        #1;
        chk("R7 random ce low", 32'(power_down), 32'd1);
        idle(2);
        chip_en = 1'b1;
        idle(2);
      end
      check_all();
    end

    // R10: reset clears everything again
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
    model_clear();
    idle(2);
    check_all();

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule